// File: doc/BRIEF.md
# Flash protection-register program sequencer

This controller sits on the host side of a parallel NOR-style flash and runs the complete program sequence for the one-time protection register. A single `start` pulse, together with an operation address and a data word, makes it write the setup command, write the data, and then poll the device status until the device reports that it is ready. It then classifies the status into exactly one result flag and marks the end of the operation with a one-cycle `done` pulse.

Every bus access holds its write or read strobe for a fixed number of clock cycles, set by a parameter. All accesses, including the command write and the status reads, use the operation address, because any address inside the target bank is accepted. If the status reports a fault, or if the device never becomes ready within a configurable number of reads, the controller locks. While it is locked, `busy` stays high and new starts are refused. A clear request writes the clear-status command, and only that write releases the lock.

Top module: `prot_prog_seq`

## Requirements
- R1: An accepted start produces exactly two bus writes before any read: first the value 0xC0 (zero-extended to the data width), then `op_data`. Every write and every status read of the operation drives `fl_addr` with the `op_addr` that was captured at the start.
- R2: After the two writes, the controller reads the status repeatedly. It stops after the first read in which bit 7 is 1, so a device that is not ready for K reads costs exactly K+1 reads. Error bits that appear in a not-ready read are ignored.
- R3: On the ready read, bit 3 sets `err_vpp`. Otherwise bit 4 sets `err_prog`. Otherwise bit 1 sets `err_prot`. Otherwise `ok` is set. Exactly one of `ok`, `err_vpp`, `err_prog`, `err_prot` and `err_tmo` is high while `done` is high.
- R4: `done` is high for exactly one cycle. It rises (2+N)·(WAIT+2) clock edges after the edge that samples `start`, where N is the number of status reads. The result flags hold their values after `done` falls.
- R5: Each strobe (`fl_we` or `fl_oe`) stays high for exactly WAIT cycles. The two strobes are never high together, and `fl_addr` and `fl_wdata` stay stable while a strobe is high.
- R6: After any error, `busy` stays high and the error flag stays set. A `start` in this state is ignored: it causes no bus access and no change of the flags.
- R7: A `clr_req` in the locked state writes 0x50 to `op_addr`, after which `busy` falls and all result flags clear. A `clr_req` while not locked causes no bus access.
- R8: If POLL_MAX status reads all show bit 7 as 0, the operation ends with `err_tmo` and `done`, and the controller locks as in R6.
- R9: After reset, `fl_we`, `fl_oe`, `busy`, `done` and all result flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a program operation (accepted when idle) |
| op_addr | input | AW | Target address inside the bank |
| op_data | input | DW | Word to program |
| clr_req | input | 1 | Issue clear-status and release the lock |
| fl_addr | output | AW | Flash address bus |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data (status in bits 7:0) |
| fl_we | output | 1 | Write strobe |
| fl_oe | output | 1 | Read strobe |
| busy | output | 1 | Operation running or error locked |
| done | output | 1 | One-cycle end-of-operation pulse |
| ok | output | 1 | Operation succeeded |
| err_vpp | output | 1 | Supply-voltage fault |
| err_prog | output | 1 | Program failure |
| err_prot | output | 1 | Target block protected |
| err_tmo | output | 1 | Ready never seen within POLL_MAX reads |

## Verification
Each bus access takes WAIT+2 edges: one to launch the strobe, WAIT with the strobe high, and one to return the acknowledge. The result is therefore due exactly (2+N)·(WAIT+2) edges after `start` is sampled. The bench drives `start` at a falling edge, counts falling edges until `done`, and compares the count with that formula plus one. It also checks at the next falling edge that `done` has fallen and that the flags are held. The lock and clear checks wait a fixed number of cycles, or for `busy` to fall, before they compare the bus write log kept by the flash model. The results therefore never depend on when the strobes happen within those windows.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_PGM, S_POLL, S_LOCK, S_CLR
  } seq_state_t;

  localparam logic [7:0] CMD_PROT_PGM = 8'hC0;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;

  localparam int BIT_READY = 7;
  localparam int BIT_VPP   = 3;
  localparam int BIT_PFAIL = 4;
  localparam int BIT_PROT  = 1;

  typedef struct packed {
    logic ok;
    logic vpp;
    logic pfail;
    logic prot;
  } stat_res_t;
endpackage

// File: rtl/pps_bus_cycle.sv
module pps_bus_cycle #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int WAIT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          is_rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rdata_in,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o,
  output logic          oe_o,
  output logic          ack,
  output logic [DW-1:0] rdata_q
);
  localparam int CW = (WAIT > 1) ? $clog2(WAIT) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      wdata_o <= '0;
      we_o    <= 1'b0;
      oe_o    <= 1'b0;
      ack     <= 1'b0;
      rdata_q <= '0;
      cnt     <= '0;
    end else begin
      ack <= 1'b0;
      if (go) begin
        addr_o  <= addr;
        wdata_o <= is_rd ? '0 : wdata;
        we_o    <= !is_rd;
        oe_o    <= is_rd;
        cnt     <= CW'(WAIT - 1);
      end else if (we_o || oe_o) begin
        if (cnt == '0) begin
          we_o <= 1'b0;
          oe_o <= 1'b0;
          ack  <= 1'b1;
          if (oe_o) rdata_q <= rdata_in;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pps_status_dec.sv
module pps_status_dec
  import pps_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] status,
  output logic          ready,
  output stat_res_t     res
);
  always_comb begin
    ready     = status[BIT_READY];
    res       = '0;
    if (status[BIT_VPP])        res.vpp   = 1'b1;
    else if (status[BIT_PFAIL]) res.pfail = 1'b1;
    else if (status[BIT_PROT])  res.prot  = 1'b1;
    else                        res.ok    = 1'b1;
  end
endmodule

// File: rtl/prot_prog_seq.sv
module prot_prog_seq
  import pps_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int WAIT     = 3,
  parameter int POLL_MAX = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  input  logic          clr_req,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata,
  output logic          fl_we,
  output logic          fl_oe,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic          err_vpp,
  output logic          err_prog,
  output logic          err_prot,
  output logic          err_tmo
);
  localparam int PCW = $clog2(POLL_MAX + 1);

  seq_state_t    state;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic [DW-1:0] wd_q;
  logic          go_q, rd_q;
  logic [PCW-1:0] pcnt;
  logic          ack, ready;
  logic [DW-1:0] st_q;
  stat_res_t     res;

  pps_bus_cycle #(.AW(AW), .DW(DW), .WAIT(WAIT)) u_bus (
    .clk(clk), .rst(rst), .go(go_q), .is_rd(rd_q),
    .addr(a_q), .wdata(wd_q), .rdata_in(fl_rdata),
    .addr_o(fl_addr), .wdata_o(fl_wdata), .we_o(fl_we), .oe_o(fl_oe),
    .ack(ack), .rdata_q(st_q)
  );

  pps_status_dec #(.DW(DW)) u_dec (
    .status(st_q), .ready(ready), .res(res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      a_q      <= '0;
      d_q      <= '0;
      wd_q     <= '0;
      go_q     <= 1'b0;
      rd_q     <= 1'b0;
      pcnt     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      ok       <= 1'b0;
      err_vpp  <= 1'b0;
      err_prog <= 1'b0;
      err_prot <= 1'b0;
      err_tmo  <= 1'b0;
    end else begin
      go_q <= 1'b0;
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          a_q      <= op_addr;
          d_q      <= op_data;
          wd_q     <= DW'(CMD_PROT_PGM);
          rd_q     <= 1'b0;
          go_q     <= 1'b1;
          busy     <= 1'b1;
          ok       <= 1'b0;
          err_vpp  <= 1'b0;
          err_prog <= 1'b0;
          err_prot <= 1'b0;
          err_tmo  <= 1'b0;
          state    <= S_CMD;
        end
        S_CMD: if (ack) begin
          wd_q  <= d_q;
          rd_q  <= 1'b0;
          go_q  <= 1'b1;
          state <= S_PGM;
        end
        S_PGM: if (ack) begin
          rd_q  <= 1'b1;
          go_q  <= 1'b1;
          pcnt  <= PCW'(1);
          state <= S_POLL;
        end
        S_POLL: if (ack) begin
          if (ready) begin
            done     <= 1'b1;
            ok       <= res.ok;
            err_vpp  <= res.vpp;
            err_prog <= res.pfail;
            err_prot <= res.prot;
            if (res.ok) begin
              busy  <= 1'b0;
              state <= S_IDLE;
            end else begin
              state <= S_LOCK;
            end
          end else if (pcnt == PCW'(POLL_MAX)) begin
            done    <= 1'b1;
            err_tmo <= 1'b1;
            state   <= S_LOCK;
          end else begin
            rd_q <= 1'b1;
            go_q <= 1'b1;
            pcnt <= pcnt + 1'b1;
          end
        end
        S_LOCK: if (clr_req) begin
          wd_q  <= DW'(CMD_CLR_STAT);
          rd_q  <= 1'b0;
          go_q  <= 1'b1;
          state <= S_CLR;
        end
        S_CLR: if (ack) begin
          busy     <= 1'b0;
          ok       <= 1'b0;
          err_vpp  <= 1'b0;
          err_prog <= 1'b0;
          err_prot <= 1'b0;
          err_tmo  <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int WAIT = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_wdata,
  input logic          fl_we,
  input logic          fl_oe,
  input logic          busy,
  input logic          done,
  input logic          ok,
  input logic          err_vpp,
  input logic          err_prog,
  input logic          err_prot,
  input logic          err_tmo
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (fl_we || fl_oe) hi_cnt <= hi_cnt + 16'd1;
    else hi_cnt <= '0;
  end

  p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_oe));

  p_strobe_width_r5: assert property (@(posedge clk) disable iff (rst)
    (!(fl_we || fl_oe) && hi_cnt != 16'd0) |-> hi_cnt == 16'(WAIT));

  p_bus_stable_r5: assert property (@(posedge clk) disable iff (rst)
    ((fl_we || fl_oe) && $past(fl_we || fl_oe)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

  p_one_result_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot({ok, err_vpp, err_prog, err_prot, err_tmo}));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_err_locks_r6: assert property (@(posedge clk) disable iff (rst)
    (err_vpp || err_prog || err_prot || err_tmo) |-> busy);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(fl_we || fl_oe));
endmodule

bind prot_prog_seq pps_checker #(.AW(AW), .DW(DW), .WAIT(WAIT)) u_chk (
  .clk(clk), .rst(rst), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
  .fl_we(fl_we), .fl_oe(fl_oe), .busy(busy), .done(done), .ok(ok),
  .err_vpp(err_vpp), .err_prog(err_prog), .err_prot(err_prot), .err_tmo(err_tmo)
);

// File: tb/sim_prot_prog_seq.sv
module sim_prot_prog_seq;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int WAIT = 2;
  localparam int PM = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, clr_req = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_data = '0;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata, fl_rdata;
  logic fl_we, fl_oe, busy, done, ok, err_vpp, err_prog, err_prot, err_tmo;

  always #2 clk = ~clk;

  prot_prog_seq #(.AW(AW), .DW(DW), .WAIT(WAIT), .POLL_MAX(PM)) u0 (
    .clk(clk), .rst(rst), .start(start), .op_addr(op_addr), .op_data(op_data),
    .clr_req(clr_req), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_we(fl_we), .fl_oe(fl_oe), .busy(busy), .done(done), .ok(ok),
    .err_vpp(err_vpp), .err_prog(err_prog), .err_prot(err_prot), .err_tmo(err_tmo)
  );

  // flash model
  logic [DW-1:0] st_final = '0;
  int k_busy = 0, rd_base = 0;
  int rd_total = 0, wr_total = 0, bad_rd = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [AW-1:0] wr_a [0:15];
  logic [DW-1:0] wr_d [0:15];
  logic we_q = 1'b0, oe_q = 1'b0;

  assign fl_rdata = ((rd_total - rd_base) >= k_busy) ? st_final : 16'h001A;

  always @(posedge clk) begin
    we_q <= fl_we;
    oe_q <= fl_oe;
    if (fl_we && !we_q) begin
      wr_a[wr_total % 16] <= fl_addr;
      wr_d[wr_total % 16] <= fl_wdata;
      wr_total <= wr_total + 1;
    end
    if (oe_q && !fl_oe) rd_total <= rd_total + 1;
    if (fl_oe && !oe_q && fl_addr != exp_addr) bad_rd <= bad_rd + 1;
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [2:0] bits, input int k);
    int n, wb, reads, ops;
    bit tmo, e_vpp, e_prog, e_prot, e_ok, is_err;
    st_final = 16'h0080 | (DW'(bits[1]) << 3) | (DW'(bits[2]) << 4) | (DW'(bits[0]) << 1);
    k_busy = k;
    @(negedge clk);
    rd_base = rd_total;
    wb = wr_total;
    exp_addr = a;
    tmo = (k >= PM);
    reads = tmo ? PM : k + 1;
    ops = 2 + reads;
    e_vpp  = !tmo && bits[1];
    e_prog = !tmo && !bits[1] && bits[2];
    e_prot = !tmo && !bits[1] && !bits[2] && bits[0];
    e_ok   = !tmo && !e_vpp && !e_prog && !e_prot;
    is_err = !e_ok;
    start = 1'b1; op_addr = a; op_data = d;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(n == ops * (WAIT + 2) + 1, "R4 done latency", n, ops * (WAIT + 2) + 1);
    chk(ok == e_ok && err_vpp == e_vpp && err_prog == e_prog && err_prot == e_prot,
        "R3 result flags", {ok, err_vpp, err_prog, err_prot}, {e_ok, e_vpp, e_prog, e_prot});
    chk(err_tmo == tmo, "R8 timeout flag", err_tmo, tmo);
    chk((rd_total - rd_base) == reads, "R2 status read count", rd_total - rd_base, reads);
    chk(wr_total - wb == 2, "R1 write count", wr_total - wb, 2);
    chk(wr_d[wb % 16] == 16'h00C0 && wr_a[wb % 16] == a, "R1 setup command write",
        wr_d[wb % 16], 16'h00C0);
    chk(wr_d[(wb + 1) % 16] == d && wr_a[(wb + 1) % 16] == a, "R1 data write",
        wr_d[(wb + 1) % 16], d);
    chk(bad_rd == 0, "R1 read address", bad_rd, 0);
    @(negedge clk);
    chk(!done, "R4 done single cycle", done, 0);
    chk(err_vpp == e_vpp && err_prog == e_prog && err_prot == e_prot && err_tmo == tmo && ok == e_ok,
        "R4 flags held", {ok, err_vpp, err_prog, err_prot, err_tmo},
        {e_ok, e_vpp, e_prog, e_prot, tmo});
    chk(busy == is_err, "R6 busy after result", busy, is_err);
    if (is_err) begin
      start = 1'b1; op_addr = a ^ 12'h0F0; op_data = ~d;
      @(negedge clk);
      start = 1'b0;
      repeat (12) @(negedge clk);
      chk(wr_total - wb == 2 && busy, "R6 start ignored while locked", wr_total - wb, 2);
      chk(err_vpp == e_vpp && err_prog == e_prog && err_prot == e_prot && err_tmo == tmo,
          "R6 error flag held", {err_vpp, err_prog, err_prot, err_tmo}, {e_vpp, e_prog, e_prot, tmo});
      clr_req = 1'b1;
      @(negedge clk);
      clr_req = 1'b0;
      n = 0;
      while (busy && n < 50) begin
        @(negedge clk);
        n++;
      end
      chk(!busy, "R7 busy released by clear", busy, 0);
      chk(wr_total - wb == 3, "R7 clear write count", wr_total - wb, 3);
      chk(wr_d[(wb + 2) % 16] == 16'h0050 && wr_a[(wb + 2) % 16] == a, "R7 clear command",
          wr_d[(wb + 2) % 16], 16'h0050);
      chk({ok, err_vpp, err_prog, err_prot, err_tmo} == 5'b0, "R7 flags cleared",
          {ok, err_vpp, err_prog, err_prot, err_tmo}, 0);
    end else begin
      clr_req = 1'b1;
      @(negedge clk);
      clr_req = 1'b0;
      repeat (10) @(negedge clk);
      chk(wr_total - wb == 2 && !busy, "R7 clear ignored when idle", wr_total - wb, 2);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!fl_we && !fl_oe && !busy && !done &&
        {ok, err_vpp, err_prog, err_prot, err_tmo} == 5'b0,
        "R9 reset state", {fl_we, fl_oe, busy, done}, 0);
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k <= PM; k++) begin
        run_op(AW'(12'h100 + b * 37 + k * 5), DW'(16'hA500 + b * 16 + k), 3'(b), k);
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule